// File: doc/BRIEF.md
# Concatenable Dual-Channel PWM Pair

This block holds two pulse-width modulation channels of `CH_W` bits each. Each channel has a period and a duty register and its own counter. Each channel also has four control bits: enable, polarity, clock select and centre alignment. A single join bit in the control register either keeps the two channels as independent PWMs or fuses them into one channel of twice the width. In fused mode the even channel's period and duty registers supply the upper half of the wide values and the odd channel's registers supply the lower half. The fused waveform leaves on the odd channel's pin, and only the odd channel's control bits govern it.

Counting is paced by two scaled clock enables that arrive from outside the block. Each channel picks one of them. A small byte-wide write port loads the registers. A combinational read port returns what was written. The control register mirrors a wider layout in which four channel pairs each own a join bit. Only the join bit of the pair selected by `PAIR_IDX` is implemented. The other three ignore writes and read back 0.

Top module: `pwm_pair_top`

## Requirements
- R1: After reset the control register reads 0 and both channels are disabled with polarity 0, so both pins are high.
- R2: Register addresses are: 0 control, 1 channel configuration, 2 even period, 3 odd period, 4 even duty, 5 odd duty. In the configuration byte, bit 0/1 enables the even/odd channel, bit 2/3 is the even/odd polarity, bit 4/5 is the even/odd clock select and bit 6/7 is the even/odd centre-align bit.
- R3: In left-aligned mode an enabled counter steps 0,1,…,period−1 and wraps. The pin equals the polarity bit while count < duty and its inverse otherwise. A period of 0 holds the count at 0.
- R4: In centre-aligned mode the counter steps up from 0 to period and back down to 0, so one cycle lasts 2×period steps. The pin follows the same count < duty rule, so it changes at the duty match on both slopes.
- R5: A counter advances only on cycles where its selected enable is high: `clk_en_b` when its clock-select bit is 1, `clk_en_a` when it is 0. Otherwise the counter holds.
- R6: Period and duty values written while a channel runs take effect only when its counter returns to 0 at the end of a period. A disabled channel takes them at once.
- R7: A disabled channel holds its count at 0 and drives the inverse of its polarity bit. When it is enabled again it starts from count 0.
- R8: With the join bit set, the even registers form the upper byte and the odd registers the lower byte of a 2×`CH_W`-bit period, duty and counter. The fused waveform appears on `pwm_out[1]`. The odd channel's enable, polarity, clock select and alignment bits control it.
- R9: With the join bit set, `pwm_out[0]` is held low and the even channel's enable, polarity, clock-select and alignment bits have no effect on either pin.
- R10: A write to the control register leaves the join bit unchanged while either channel of the pair is enabled. The other control bits are still written.
- R11: In the control register the join bit of pair p sits at bit 4+p (p = `PAIR_IDX`). Bit 3 is a stop-in-wait flag and bit 2 a stop-in-freeze flag, both stored and read back. Join bits of the other pairs and bits 1..0 ignore writes and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en_a | input | 1 | First scaled counting enable |
| clk_en_b | input | 1 | Second scaled counting enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CH_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CH_W | Register read data (combinational) |
| pwm_out | output | 2 | Bit 0 even channel pin, bit 1 odd channel pin |

## Verification
The bench builds the block with `CH_W` = 8 and `PAIR_IDX` = 2, so the join bit sits at bit 6 and a write of all ones to the control register must read back exactly bits 6, 3 and 2. The 8-bit width keeps the separate-channel periods short, so several complete wraps and centre-aligned up/down sweeps fit into a few dozen cycles. The fused 16-bit periods of 261 and 256 cross the byte boundary, which shows that the upper half really comes from the even registers. Holding `clk_en_b` low while selecting it freezes the counters and exposes the clock-select path.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG   = 3'd1;
  localparam logic [ADDR_W-1:0] A_PER0  = 3'd2;
  localparam logic [ADDR_W-1:0] A_PER1  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DUTY0 = 3'd4;
  localparam logic [ADDR_W-1:0] A_DUTY1 = 3'd5;

  typedef struct packed {
    logic cae;
    logic csel;
    logic pol;
    logic en;
  } chan_cfg_t;

endpackage

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs
  import pwm_pair_pkg::*;
#(
  parameter int CH_W     = 8,
  parameter int PAIR_IDX = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [CH_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [CH_W-1:0]        rd_data,
  output logic                   concat,
  output chan_cfg_t [1:0]        cfg,
  output logic [1:0][CH_W-1:0]   per,
  output logic [1:0][CH_W-1:0]   duty
);

  localparam int JOIN_BIT = 4 + PAIR_IDX;

  logic                 join_q, join_d;
  logic                 swait_q, swait_d;
  logic                 sfrz_q, sfrz_d;
  logic [7:0]           cfg_q, cfg_d;
  logic [1:0][CH_W-1:0] per_q, per_d;
  logic [1:0][CH_W-1:0] duty_q, duty_d;
  logic                 pair_busy;
  logic [7:0]           ctrl_view;

  assign pair_busy = cfg_q[0] | cfg_q[1];

  always_comb begin
    join_d  = join_q;
    swait_d = swait_q;
    sfrz_d  = sfrz_q;
    cfg_d   = cfg_q;
    per_d   = per_q;
    duty_d  = duty_q;
    if (wr_en) begin
      unique case (wr_addr)
        A_CTRL: begin
          if (!pair_busy) join_d = wr_data[JOIN_BIT];
          swait_d = wr_data[3];
          sfrz_d  = wr_data[2];
        end
        A_CFG:   cfg_d     = wr_data[7:0];
        A_PER0:  per_d[0]  = wr_data;
        A_PER1:  per_d[1]  = wr_data;
        A_DUTY0: duty_d[0] = wr_data;
        A_DUTY1: duty_d[1] = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      join_q  <= 1'b0;
      swait_q <= 1'b0;
      sfrz_q  <= 1'b0;
      cfg_q   <= '0;
      per_q   <= '0;
      duty_q  <= '0;
    end else begin
      join_q  <= join_d;
      swait_q <= swait_d;
      sfrz_q  <= sfrz_d;
      cfg_q   <= cfg_d;
      per_q   <= per_d;
      duty_q  <= duty_d;
    end
  end

  always_comb begin
    ctrl_view           = 8'h00;
    ctrl_view[JOIN_BIT] = join_q;
    ctrl_view[3]        = swait_q;
    ctrl_view[2]        = sfrz_q;
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_CTRL:  rd_data[7:0] = ctrl_view;
      A_CFG:   rd_data[7:0] = cfg_q;
      A_PER0:  rd_data = per_q[0];
      A_PER1:  rd_data = per_q[1];
      A_DUTY0: rd_data = duty_q[0];
      A_DUTY1: rd_data = duty_q[1];
      default: rd_data = '0;
    endcase
  end

  assign concat = join_q;
  assign per    = per_q;
  assign duty   = duty_q;

  always_comb begin
    cfg[0] = '{cae: cfg_q[6], csel: cfg_q[4], pol: cfg_q[2], en: cfg_q[0]};
    cfg[1] = '{cae: cfg_q[7], csel: cfg_q[5], pol: cfg_q[3], en: cfg_q[1]};
  end

  AST_CONCAT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    pair_busy |=> (join_q == $past(join_q))); // R10

endmodule

// File: rtl/pwm_wave_core.sv
module pwm_wave_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic         center,
  input  logic         pol,
  input  logic [W-1:0] per_sh,
  input  logic [W-1:0] duty_sh,
  output logic         out
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] per_q, per_d;
  logic [W-1:0] duty_q, duty_d;
  logic         down_q, down_d;
  logic         load;

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    load   = 1'b0;
    if (!en) begin
      cnt_d  = '0;
      down_d = 1'b0;
      load   = 1'b1;
    end else if (tick) begin
      if (!center) begin
        down_d = 1'b0;
        if ((per_q == '0) || (cnt_q >= per_q - ONE)) begin
          cnt_d = '0;
          load  = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else if (down_q) begin
        if (cnt_q <= ONE) begin
          cnt_d  = '0;
          down_d = 1'b0;
          load   = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end else if (cnt_q >= per_q) begin
        if (per_q <= ONE) begin
          cnt_d = '0;
          load  = 1'b1;
        end else begin
          cnt_d  = cnt_q - ONE;
          down_d = 1'b1;
        end
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
    per_d  = load ? per_sh  : per_q;
    duty_d = load ? duty_sh : duty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      per_q  <= '0;
      duty_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
      per_q  <= per_d;
      duty_q <= duty_d;
    end
  end

  assign out = (en && (cnt_q < duty_q)) ? pol : ~pol;

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0)); // R7

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> (cnt_q == $past(cnt_q))); // R5

  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_q); // R3

  AST_BUFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load) |=> ($stable(per_q) && $stable(duty_q))); // R6

endmodule

// File: rtl/pwm_pair_top.sv
module pwm_pair_top
  import pwm_pair_pkg::*;
#(
  parameter int CH_W     = 8,
  parameter int PAIR_IDX = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_en_a,
  input  logic            clk_en_b,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [CH_W-1:0] wr_data,
  input  logic [2:0]      rd_addr,
  output logic [CH_W-1:0] rd_data,
  output logic [1:0]      pwm_out
);

  localparam int WIDE_W = 2 * CH_W;

  logic [1:0]           rst_sync_q;
  logic                 rst_n_int;
  logic                 concat;
  chan_cfg_t [1:0]      cfg;
  logic [1:0][CH_W-1:0] per;
  logic [1:0][CH_W-1:0] duty;
  logic [1:0]           solo_out;
  logic                 wide_out;
  logic                 wide_en;
  logic                 wide_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  pwm_ctrl_regs #(.CH_W(CH_W), .PAIR_IDX(PAIR_IDX)) i_regs (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .concat  (concat),
    .cfg     (cfg),
    .per     (per),
    .duty    (duty)
  );

  for (genvar g = 0; g < 2; g++) begin : g_solo
    logic solo_en;
    logic solo_tick;
    assign solo_en   = cfg[g].en & ~concat;
    assign solo_tick = cfg[g].csel ? clk_en_b : clk_en_a;
    pwm_wave_core #(.W(CH_W)) i_core (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .en      (solo_en),
      .tick    (solo_tick),
      .center  (cfg[g].cae),
      .pol     (cfg[g].pol),
      .per_sh  (per[g]),
      .duty_sh (duty[g]),
      .out     (solo_out[g])
    );
  end

  assign wide_en   = cfg[1].en & concat;
  assign wide_tick = cfg[1].csel ? clk_en_b : clk_en_a;

  pwm_wave_core #(.W(WIDE_W)) i_wide (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .en      (wide_en),
    .tick    (wide_tick),
    .center  (cfg[1].cae),
    .pol     (cfg[1].pol),
    .per_sh  ({per[0], per[1]}),
    .duty_sh ({duty[0], duty[1]}),
    .out     (wide_out)
  );

  assign pwm_out[0] = concat ? 1'b0     : solo_out[0];
  assign pwm_out[1] = concat ? wide_out : solo_out[1];

  AST_SOLO_IDLE_IN_CONCAT: assert property (@(posedge clk) disable iff (!rst_n_int)
    concat |-> (solo_out[0] == ~cfg[0].pol)); // R9

endmodule

// File: tb/test_pwm_pair_top.sv
module test_pwm_pair_top;

  localparam int W  = 8;
  localparam int PI = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         clk_en_a;
  logic         clk_en_b;
  logic         wr_en;
  logic [2:0]   wr_addr;
  logic [W-1:0] wr_data;
  logic [2:0]   rd_addr;
  logic [W-1:0] rd_data;
  logic [1:0]   pwm_out;

  always #4 clk = ~clk;

  pwm_pair_top #(.CH_W(W), .PAIR_IDX(PI)) i_pwm_pair_top (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en_a (clk_en_a),
    .clk_en_b (clk_en_b),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .pwm_out  (pwm_out)
  );

  typedef struct {
    logic [1:0] val;
    string      req;
  } exp_item_t;

  exp_item_t sb_q[$];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: samples 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_item_t it;
      it = sb_q.pop_front();
      check(it.req, {6'd0, pwm_out}, {6'd0, it.val});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input logic [2:0] a, input logic [7:0] exp, input string req);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  function automatic logic lvl_left(int t, int per, int duty, logic pol);
    int c;
    c = (per == 0) ? 0 : (t % per);
    return (c < duty) ? pol : ~pol;
  endfunction

  function automatic logic lvl_center(int t, int per, int duty, logic pol);
    int c;
    if (per == 0) c = 0;
    else begin
      c = t % (2 * per);
      if (c > per) c = 2 * per - c;
    end
    return (c < duty) ? pol : ~pol;
  endfunction

  task automatic push(logic [1:0] v, string req);
    exp_item_t it;
    it.val = v;
    it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic drain();
    wait (sb_q.size() == 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; clk_en_a = 1'b1; clk_en_b = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_check(3'd0, 8'h00, "R1");
    check("R1", {6'd0, pwm_out}, 8'h03);

    // R11: only bit 4+PAIR_IDX, 3, 2 are kept
    wr(3'd0, 8'hFF);
    rd_check(3'd0, 8'h4C, "R11");
    wr(3'd0, 8'h00);
    rd_check(3'd0, 8'h00, "R11");

    // R2/R3: two independent left-aligned channels
    wr(3'd2, 8'd5); wr(3'd4, 8'd2);
    wr(3'd3, 8'd4); wr(3'd5, 8'd3);
    rd_check(3'd2, 8'd5, "R2");
    wr(3'd1, 8'h07);
    for (int t = 1; t <= 20; t++)
      push({lvl_left(t, 4, 3, 1'b0), lvl_left(t, 5, 2, 1'b1)}, "R3");
    drain();

    // R7: disabled pins sit at inverse polarity
    wr(3'd1, 8'h04);
    check("R7", {6'd0, pwm_out}, 8'h02);
    repeat (3) @(negedge clk);
    check("R7", {6'd0, pwm_out}, 8'h02);

    // R4: centre-aligned odd channel
    wr(3'd3, 8'd4); wr(3'd5, 8'd2);
    wr(3'd1, 8'h8A);
    for (int t = 1; t <= 24; t++)
      push({lvl_center(t, 4, 2, 1'b1), 1'b1}, "R4");
    drain();
    wr(3'd1, 8'h00);

    // R6: duty written mid-period waits for the wrap
    wr(3'd2, 8'd4); wr(3'd4, 8'd2);
    wr(3'd1, 8'h05);
    wr(3'd4, 8'd4);
    for (int t = 3; t <= 14; t++)
      push({1'b1, ((t % 4) < ((t < 4) ? 2 : 4)) ? 1'b1 : 1'b0}, "R6");
    drain();
    wr(3'd1, 8'h00);

    // R5: even channel on clk_en_b, held low -> frozen at count 0
    wr(3'd4, 8'd2);
    wr(3'd1, 8'h15);
    for (int t = 1; t <= 10; t++) push(2'b11, "R5");
    drain();
    wr(3'd1, 8'h00);

    // R8/R9: fused 16-bit left-aligned, even controls set but ignored
    wr(3'd0, 8'h40);
    rd_check(3'd0, 8'h40, "R8");
    wr(3'd2, 8'h01); wr(3'd3, 8'h05);
    wr(3'd4, 8'h00); wr(3'd5, 8'h82);
    wr(3'd1, 8'h4F);
    for (int t = 1; t <= 300; t++)
      push({lvl_left(t, 261, 130, 1'b1), 1'b0}, "R8,R9");
    drain();

    // R10: join bit locked while enabled
    wr(3'd0, 8'h00);
    rd_check(3'd0, 8'h40, "R10");

    // R8/R4: fused centre-aligned
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h01); wr(3'd3, 8'h00);
    wr(3'd4, 8'h00); wr(3'd5, 8'h40);
    wr(3'd1, 8'h8A);
    for (int t = 1; t <= 520; t++)
      push({lvl_center(t, 256, 64, 1'b1), 1'b0}, "R8");
    drain();

    // R5 in fused mode: odd clock select picks the stalled enable
    wr(3'd1, 8'h00);
    wr(3'd1, 8'h2A);
    for (int t = 1; t <= 16; t++) push(2'b10, "R5");
    drain();

    // R10: unlocked once disabled
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h00);
    rd_check(3'd0, 8'h00, "R10");
    check("R7", {6'd0, pwm_out}, 8'h03);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule